// File: doc/BRIEF.md
# Dual-Edge Interleaved Sample Capture

This block takes one parallel code bus that carries samples for two converter channels, one after the other within each clock period. It produces two channel code registers that always change on the same clock edge. During the low phase of the clock the bus holds the channel 2 sample, and the falling edge parks that sample in a preload latch. During the high phase the bus holds the channel 1 sample. The next rising edge captures channel 1 from the bus and moves the parked channel 2 sample into its output register at the same moment.

An active-low select gates every capture. A hold input, driven by a power-mode controller, freezes the two output registers while the preload latch keeps tracking the bus. A one-cycle strobe marks each rising edge on which both outputs took new codes. Reset is synchronous and active high. It is sampled by the falling-edge latch on falling edges and by the rising-edge registers on rising edges.

Top module: `dual_edge_capture`

## Requirements
- R1: The code bus is `CODE_W` bits wide (default 10). Bus bit i reaches bit i of the channel code unchanged, with bit `CODE_W-1` the most significant and bit 0 the least significant.
- R2: On a falling clock edge with `cs_n` low, the preload latch takes the bus value.
- R3: On a rising clock edge with `cs_n` low and `hold` low, `ch1_code` takes the bus value present at that edge.
- R4: On that same rising edge, `ch2_code` takes the preload latch contents, so a sample pair placed on the bus as channel 2 (low phase) then channel 1 (high phase) appears on both outputs after one rising edge.
- R5: `cs_n` high at a falling edge leaves the preload latch unchanged. `cs_n` high at a rising edge leaves both channel codes unchanged.
- R6: `update_valid` is high for exactly the one cycle after each rising edge that loaded both channel codes, and low after every other rising edge.
- R7: While `rst` is high, both channel codes and the preload latch are cleared to zero and `update_valid` is low.
- R8: `hold` high at a rising edge keeps both channel codes. The preload latch still captures on falling edges while `hold` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; falling edge feeds the preload latch, rising edge the outputs |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select qualifying each edge |
| hold | input | 1 | Freeze request for the output registers |
| bus_in | input | CODE_W | Interleaved sample bus |
| ch1_code | output | CODE_W | Channel 1 code register |
| ch2_code | output | CODE_W | Channel 2 code register |
| update_valid | output | 1 | One-cycle strobe after a joint load |

## Verification
The bench sweeps all 1024 channel 2 codes, paired with scrambled channel 1 codes. Over this sweep, select and hold are toggled independently at the falling edge and at the rising edge. A design that let channel 2 bypass the preload latch, or captured it on the rising edge, would show the high-phase value on `ch2_code`. A design that ignored select at the falling edge would show a refreshed channel 2 code where the stale one is expected. A hold that also froze the preload latch would fail the case where hold drops just after a falling edge, because the sample captured under hold would never appear. Directed cases cover MSB and LSB placement and a mid-run reset that must clear the hidden latch, which the next load then exposes as zero on `ch2_code`.

// File: rtl/dcap_pkg.sv
package dcap_pkg;

    localparam int unsigned DEF_CODE_W = 10;
    localparam int unsigned NUM_CH     = 2;

    // Source that feeds a channel output register at the rising edge.
    typedef enum logic {
        SRC_BUS     = 1'b0,
        SRC_PRELOAD = 1'b1
    } chan_src_e;

    // Channel 0 (channel 1 at the ports) samples the bus directly; the
    // rest are served from the falling-edge preload latch.
    function automatic chan_src_e src_for(input int unsigned idx);
        return (idx == 0) ? SRC_BUS : SRC_PRELOAD;
    endfunction

    // Joint-load qualifier shared by the output registers and the strobe.
    function automatic logic load_ok(input logic sel_n, input logic frz);
        return (!sel_n) && (!frz);
    endfunction

endpackage

// File: rtl/dcap_preload.sv
module dcap_preload #(
    parameter int unsigned W = dcap_pkg::DEF_CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(negedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!cs_n) begin
            q <= d;
        end
    end

    AST_PRE_CAPTURE: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && !$past(cs_n)) |-> (q == $past(d))); // R2

    AST_PRE_KEEP_DESELECTED: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && $past(cs_n)) |-> $stable(q)); // R5

endmodule

// File: rtl/dcap_chan_reg.sv
module dcap_chan_reg #(
    parameter int unsigned W = dcap_pkg::DEF_CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load_en) begin
            q <= d;
        end
    end

    AST_CHAN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_en)) |-> (q == $past(d))); // R3

    AST_CHAN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_en)) |-> $stable(q)); // R8

endmodule

// File: rtl/dcap_strobe.sv
module dcap_strobe (
    input  logic clk,
    input  logic rst,
    input  logic load_en,
    output logic pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= load_en;
        end
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (pulse && !$past(load_en)) |-> 1'b0); // R6

endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture #(
    parameter int unsigned CODE_W = dcap_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              hold,
    input  logic [CODE_W-1:0] bus_in,
    output logic [CODE_W-1:0] ch1_code,
    output logic [CODE_W-1:0] ch2_code,
    output logic              update_valid
);
    import dcap_pkg::*;

    localparam int unsigned NCH = NUM_CH;

    logic [CODE_W-1:0] pre_q;
    logic              load_en;
    logic [CODE_W-1:0] chan_d [NCH];
    logic [CODE_W-1:0] chan_q [NCH];

    assign load_en = load_ok(cs_n, hold);

    dcap_preload #(.W(CODE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .d    (bus_in),
        .q    (pre_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        if (src_for(g) == SRC_BUS) begin : g_bus
            assign chan_d[g] = bus_in;
        end else begin : g_pre
            assign chan_d[g] = pre_q;
        end

        dcap_chan_reg #(.W(CODE_W)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .load_en (load_en),
            .d       (chan_d[g]),
            .q       (chan_q[g])
        );
    end

    dcap_strobe u_stb (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .pulse   (update_valid)
    );

    assign ch1_code = chan_q[0];
    assign ch2_code = chan_q[1];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ch1_code == '0 && ch2_code == '0 && !update_valid)); // R7

    AST_VALID_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        update_valid |-> (!$past(cs_n) && !$past(hold))); // R6

    AST_JOINT_UPDATE: assert property (@(posedge clk) disable iff (rst)
        update_valid |-> (ch1_code == $past(bus_in) && ch2_code == $past(pre_q))); // R4

    AST_OUTPUTS_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !update_valid) |-> ($stable(ch1_code) && $stable(ch2_code))); // R5

endmodule

// File: tb/dual_edge_capture_tb.sv
module dual_edge_capture_tb_top;

    localparam int W = 10;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         hold = 1'b0;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] ch1_code, ch2_code;
    logic         update_valid;

    int checks = 0;
    int errors = 0;
    int m_pre = 0, m1 = 0, m2 = 0, mv = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dual_edge_capture #(.CODE_W(W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cs_n         (cs_n),
        .hold         (hold),
        .bus_in       (bus_in),
        .ch1_code     (ch1_code),
        .ch2_code     (ch2_code),
        .update_valid (update_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R3 ch1_code"}, int'(ch1_code), m1);
        chk({tag, " R4 ch2_code"}, int'(ch2_code), m2);
        chk({tag, " R6 update_valid"}, int'(update_valid), mv);
    endtask

    // One clock period: low-phase value b2 with select csf, then high-phase
    // value b1 with select csr; hold fixed for the whole period.
    task automatic cyc(input int b2, input int b1, input bit csf, input bit csr, input bit hld);
        cs_n = csf; bus_in = W'(b2); hold = hld;
        @(negedge clk); #1;
        if (!csf) m_pre = b2;
        cs_n = csr; bus_in = W'(b1);
        @(posedge clk); #1;
        if (!csr && !hld) begin m1 = b1; m2 = m_pre; mv = 1; end
        else mv = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1; cs_n = 1'b1; hold = 1'b0;
        @(negedge clk); @(posedge clk); @(negedge clk); @(posedge clk); #1;
        rst = 1'b0;
        m_pre = 0; m1 = 0; m2 = 0; mv = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        do_reset();
        check_all("R7 reset");

        // R1 bit placement: MSB and LSB
        cyc(1, 10'h200, 1'b0, 1'b0, 1'b0);
        chk("R1 ch1 msb", int'(ch1_code[W-1]), 1);
        chk("R1 ch1 lsb", int'(ch1_code[0]), 0);
        chk("R1 ch2 lsb", int'(ch2_code[0]), 1);
        chk("R1 ch2 msb", int'(ch2_code[W-1]), 0);

        // R2 / R5: deselected falling edge keeps stale preload
        cyc(100, 200, 1'b0, 1'b0, 1'b0);
        check_all("R2 pair");
        cyc(300, 400, 1'b1, 1'b0, 1'b0);
        chk("R5 stale preload on ch2", int'(ch2_code), 100);
        chk("R5 ch1 loads", int'(ch1_code), 400);
        cyc(500, 600, 1'b0, 1'b1, 1'b0);
        chk("R5 deselected rising ch1", int'(ch1_code), 400);
        chk("R5 deselected rising ch2", int'(ch2_code), 100);
        chk("R6 no strobe", int'(update_valid), 0);
        cyc(700, 800, 1'b1, 1'b0, 1'b0);
        chk("R2 preload from earlier edge", int'(ch2_code), 500);

        // R8: hold freezes outputs, preload still follows
        cyc(11, 22, 1'b0, 1'b0, 1'b1);
        chk("R8 held ch1", int'(ch1_code), 800);
        chk("R8 held ch2", int'(ch2_code), 500);
        cs_n = 1'b0; bus_in = W'(33); hold = 1'b1;
        @(negedge clk); #1;
        m_pre = 33;
        hold = 1'b0; bus_in = W'(44);
        @(posedge clk); #1;
        m1 = 44; m2 = 33; mv = 1;
        chk("R8 preload captured under hold", int'(ch2_code), 33);
        check_all("R8 release");

        // Sweep every channel 2 code with mixed select and hold
        for (int i = 0; i <= MAXV; i++) begin
            cyc(i, (i * 37 + 5) & MAXV, (i % 9) == 4, (i % 13) == 6, (i % 7) == 2);
            check_all("sweep");
        end

        // R7: mid-run reset clears the hidden preload latch
        cyc(999, 888, 1'b0, 1'b0, 1'b0);
        do_reset();
        check_all("R7 mid reset");
        cyc(555, 123, 1'b1, 1'b0, 1'b0);
        chk("R7 preload cleared", int'(ch2_code), 0);
        chk("R7 ch1 after reset", int'(ch1_code), 123);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule